// File: doc/BRIEF.md
# Byte-Lane SECDED Check Datapath

This block sits between a 16-bit memory-controller data path and a 32-lane DRAM data bus. On the write side it protects each of the two data bytes with its own 5-bit single-error-correct, double-error-detect code. It then places data, check bits and zero-driven spare lanes onto the 32 bus lanes. On the read side it takes the 32 lanes apart and checks each byte against its own code. Only bytes selected by the read's byte-enable mask are checked. A location where only one byte was ever written therefore reads back cleanly through that byte.

Single-bit faults are repaired without notice, and the response stays OKAY. A read with any uncorrectable selected byte returns an error response. Each error class has its own log. A log is a small two-state machine with states LOG_EMPTY and LOG_HELD. The capture transition takes LOG_EMPTY to LOG_HELD. The clear transition takes LOG_HELD back to LOG_EMPTY. A clear that meets a new error in the same cycle takes the reload transition, from LOG_HELD to LOG_HELD, and stores the new error. Each lane decoder sorts its byte into one of three classes: CLEAN, FIXED or FATAL. A saturating counter per class counts the error events.

Top module: `ecc_lane_datapath`

## Requirements
- R1: For write data bytes b0 (bits 7:0) and b1 (bits 15:8), the bus word places b0 on lanes 7:0 and b1 on lanes 15:8. The check field of b0 goes on lanes 20:16 and that of b1 on lanes 28:24. Lanes 23:21 and 31:29 are driven 0. Within a check field, data bit i takes Hamming position 3,5,6,7,9,10,11,12 for i = 0..7. Check bit k (field bit k, k = 0..3) is the XOR of the data bits whose position has bit k set. Field bit 4 is the XOR of all 8 data bits and check bits 0..3.
- R2: A read of an error-free word returns the stored data with response code 2'b00 (OKAY).
- R3: A single flipped data or Hamming check bit in a selected byte is corrected in the returned data, and the response stays OKAY.
- R4: A flip of field bit 4 alone is a correctable event. The data is returned unchanged, with response OKAY.
- R5: Two flipped bits within one selected byte give response code 2'b10 (SLVERR). That byte's data is returned exactly as read.
- R6: Bytes whose enable bit is 0 (bit 0 enables b0, bit 1 enables b1) are never checked and are returned as read. Faults in them cause neither an error response nor a log entry.
- R7: Lanes 23:21 and 31:29 are ignored on reads.
- R8: The response, its code and any log or counter update appear in the cycle after the read is presented, for exactly one cycle per read.
- R9: A read with at least one FATAL selected byte is logged to the uncorrectable log only. A read with only FIXED bytes is logged to the correctable log. The logged lane mask has bit n set for every failing selected byte n. Column, row and bank are captured with the mask. A held log keeps its first error.
- R10: A clear strobe empties its log. A clear that coincides with a new error of that class loads the new error, and the log stays valid.
- R11: Each class has a counter that adds one per logged read event and stops at its all-ones value.
- R12: After reset there is no response, both logs are empty and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_data | input | 16 | Write data, two bytes |
| wr_dq | output | 32 | Encoded bus word for writes |
| rd_valid | input | 1 | Read bus word present this cycle |
| rd_dq | input | 32 | Bus word from DRAM |
| rd_be | input | 2 | Byte enables of the read |
| rd_col | input | 10 | Column address of the read |
| rd_row | input | 15 | Row address of the read |
| rd_bank | input | 3 | Bank address of the read |
| clr_ce | input | 1 | Clear strobe for the correctable log |
| clr_ue | input | 1 | Clear strobe for the uncorrectable log |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | 16 | Corrected read data |
| rsp_code | output | 2 | 2'b00 OKAY, 2'b10 SLVERR |
| ce_valid | output | 1 | Correctable log holds an entry |
| ce_col | output | 10 | Logged column |
| ce_row | output | 15 | Logged row |
| ce_bank | output | 3 | Logged bank |
| ce_lanes | output | 2 | Logged failing-lane mask |
| ce_count | output | 8 | Correctable event counter |
| ue_valid | output | 1 | Uncorrectable log holds an entry |
| ue_col | output | 10 | Logged column |
| ue_row | output | 15 | Logged row |
| ue_bank | output | 3 | Logged bank |
| ue_lanes | output | 2 | Logged failing-lane mask |
| ue_count | output | 8 | Uncorrectable event counter |

## Verification
Two situations can land in the same cycle. In the first, one byte of a read is correctable and the other is not. The bench injects a single flip in byte 0 and a double flip in byte 1 together. It then expects SLVERR, a corrected byte 0, a raw byte 1, a mask of 2'b11 in the uncorrectable log, and an untouched correctable log. In the second, a clear strobe arrives in the same cycle as a fresh error of the same class. The bench raises the clear together with a correctable read to a new address. It then expects the log to hold that new address and to stay valid.

// File: rtl/eccl_pkg.sv
package eccl_pkg;

    localparam int LANES  = 2;
    localparam int BYTE_W = 8;
    localparam int HAM_W  = 4;
    localparam int CHK_W  = HAM_W + 1;
    localparam int DQ_W   = 32;
    localparam int CHK_BASE = LANES * BYTE_W;

    typedef enum logic [1:0] {
        RSP_OKAY   = 2'b00,
        RSP_SLVERR = 2'b10
    } rsp_e;

    typedef enum logic [1:0] {
        CLS_CLEAN,
        CLS_FIXED,
        CLS_FATAL
    } cls_e;

    typedef enum logic {
        LOG_EMPTY,
        LOG_HELD
    } log_state_e;

    // Hamming position of data bit i in a 12-position codeword
    function automatic logic [HAM_W-1:0] ham_pos(input int i);
        logic [HAM_W-1:0] p;
        unique case (i)
            0: p = 4'd3;
            1: p = 4'd5;
            2: p = 4'd6;
            3: p = 4'd7;
            4: p = 4'd9;
            5: p = 4'd10;
            6: p = 4'd11;
            default: p = 4'd12;
        endcase
        return p;
    endfunction

    function automatic logic [HAM_W-1:0] ham_bits(input logic [BYTE_W-1:0] d);
        logic [HAM_W-1:0] c;
        logic [HAM_W-1:0] p;
        c = '0;
        for (int i = 0; i < BYTE_W; i++) begin
            p = ham_pos(i);
            for (int k = 0; k < HAM_W; k++) begin
                if (p[k]) c[k] = c[k] ^ d[i];
            end
        end
        return c;
    endfunction

    function automatic logic [CHK_W-1:0] ecc_gen(input logic [BYTE_W-1:0] d);
        logic [HAM_W-1:0] c;
        c = ham_bits(d);
        return {(^d) ^ (^c), c};
    endfunction

endpackage

// File: rtl/ecc_lane_dec.sv
module ecc_lane_dec
    import eccl_pkg::*;
(
    input  logic [BYTE_W-1:0] data,
    input  logic [CHK_W-1:0]  chk,
    input  logic              sel,
    output logic [BYTE_W-1:0] fixed,
    output cls_e              cls
);

    logic [HAM_W-1:0] syn;
    logic             par_err;

    assign syn     = ham_bits(data) ^ chk[HAM_W-1:0];
    assign par_err = ^{data, chk};

    always_comb begin
        fixed = data;
        cls   = CLS_CLEAN;
        if (sel) begin
            if (syn == '0) begin
                // only the overall parity bit can be wrong here
                cls = par_err ? CLS_FIXED : CLS_CLEAN;
            end else if (!par_err) begin
                cls = CLS_FATAL;
            end else if (syn > 4'd12) begin
                cls = CLS_FATAL;
            end else begin
                cls = CLS_FIXED;
                for (int i = 0; i < BYTE_W; i++) begin
                    if (ham_pos(i) == syn) fixed[i] = ~data[i];
                end
            end
        end
    end

endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
    import eccl_pkg::*;
#(
    parameter int ADDR_W = 28,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              clear,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [LANES-1:0]  lanes_in,
    output logic              valid,
    output logic [ADDR_W-1:0] addr,
    output logic [LANES-1:0]  lanes,
    output logic [CNT_W-1:0]  count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    log_state_e state, state_nxt;
    logic       load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LOG_EMPTY;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        load      = 1'b0;
        unique case (state)
            LOG_EMPTY: begin
                if (capture) begin
                    state_nxt = LOG_HELD;
                    load      = 1'b1;
                end
            end
            LOG_HELD: begin
                if (clear) begin
                    if (capture) load = 1'b1;
                    else         state_nxt = LOG_EMPTY;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr  <= '0;
            lanes <= '0;
        end else if (load) begin
            addr  <= addr_in;
            lanes <= lanes_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           count <= '0;
        else if (capture && count != CNT_MAX) count <= count + 1'b1;
    end

    assign valid = (state == LOG_HELD);

endmodule

// File: rtl/ecc_lane_datapath.sv
module ecc_lane_datapath
    import eccl_pkg::*;
#(
    parameter int COL_W  = 10,
    parameter int ROW_W  = 15,
    parameter int BANK_W = 3,
    parameter int CNT_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [15:0]           wr_data,
    output logic [31:0]           wr_dq,
    input  logic                  rd_valid,
    input  logic [31:0]           rd_dq,
    input  logic [1:0]            rd_be,
    input  logic [COL_W-1:0]      rd_col,
    input  logic [ROW_W-1:0]      rd_row,
    input  logic [BANK_W-1:0]     rd_bank,
    input  logic                  clr_ce,
    input  logic                  clr_ue,
    output logic                  rsp_valid,
    output logic [15:0]           rsp_data,
    output logic [1:0]            rsp_code,
    output logic                  ce_valid,
    output logic [COL_W-1:0]      ce_col,
    output logic [ROW_W-1:0]      ce_row,
    output logic [BANK_W-1:0]     ce_bank,
    output logic [1:0]            ce_lanes,
    output logic [CNT_W-1:0]      ce_count,
    output logic                  ue_valid,
    output logic [COL_W-1:0]      ue_col,
    output logic [ROW_W-1:0]      ue_row,
    output logic [BANK_W-1:0]     ue_bank,
    output logic [1:0]            ue_lanes,
    output logic [CNT_W-1:0]      ue_count
);

    localparam int ADDR_W = COL_W + ROW_W + BANK_W;
    localparam int SPARE  = BYTE_W - CHK_W;

    cls_e                    lane_cls [LANES];
    logic [LANES-1:0]        lane_bad;
    logic [LANES-1:0]        lane_fatal;
    logic [LANES*BYTE_W-1:0] fix_data;
    logic [LANES*SPARE-1:0]  unused_spare;
    logic                    ce_hit;
    logic                    ue_hit;
    logic [ADDR_W-1:0]       rd_addr;
    logic [ADDR_W-1:0]       ce_addr;
    logic [ADDR_W-1:0]       ue_addr;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam int D_LSB = l * BYTE_W;
        localparam int C_LSB = CHK_BASE + l * BYTE_W;

        assign wr_dq[D_LSB +: BYTE_W]         = wr_data[D_LSB +: BYTE_W];
        assign wr_dq[C_LSB +: CHK_W]          = ecc_gen(wr_data[D_LSB +: BYTE_W]);
        assign wr_dq[C_LSB + CHK_W +: SPARE]  = '0;
        assign unused_spare[l*SPARE +: SPARE] = rd_dq[C_LSB + CHK_W +: SPARE];

        ecc_lane_dec u_dec (
            .data  (rd_dq[D_LSB +: BYTE_W]),
            .chk   (rd_dq[C_LSB +: CHK_W]),
            .sel   (rd_be[l]),
            .fixed (fix_data[D_LSB +: BYTE_W]),
            .cls   (lane_cls[l])
        );

        assign lane_bad[l]   = (lane_cls[l] != CLS_CLEAN);
        assign lane_fatal[l] = (lane_cls[l] == CLS_FATAL);
    end

    assign ue_hit  = rd_valid && (|lane_fatal);
    assign ce_hit  = rd_valid && (|lane_bad) && !(|lane_fatal);
    assign rd_addr = {rd_bank, rd_row, rd_col};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_code  <= RSP_OKAY;
        end else begin
            rsp_valid <= rd_valid;
            if (rd_valid) begin
                rsp_data <= fix_data;
                rsp_code <= (|lane_fatal) ? RSP_SLVERR : RSP_OKAY;
            end
        end
    end

    ecc_err_log #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ce_log (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (ce_hit),
        .clear    (clr_ce),
        .addr_in  (rd_addr),
        .lanes_in (lane_bad),
        .valid    (ce_valid),
        .addr     (ce_addr),
        .lanes    (ce_lanes),
        .count    (ce_count)
    );

    ecc_err_log #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ue_log (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (ue_hit),
        .clear    (clr_ue),
        .addr_in  (rd_addr),
        .lanes_in (lane_bad),
        .valid    (ue_valid),
        .addr     (ue_addr),
        .lanes    (ue_lanes),
        .count    (ue_count)
    );

    assign {ce_bank, ce_row, ce_col} = ce_addr;
    assign {ue_bank, ue_row, ue_col} = ue_addr;

endmodule

// File: rtl/ecc_datapath_chk.sv
module ecc_datapath_chk
    import eccl_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_valid,
    input logic [1:0]       rd_be,
    input logic             rsp_valid,
    input logic [1:0]       rsp_code,
    input logic             ce_valid,
    input logic [1:0]       ce_lanes,
    input logic [CNT_W-1:0] ce_count,
    input logic             ue_valid,
    input logic [1:0]       ue_lanes,
    input logic [CNT_W-1:0] ue_count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    AST_RSP_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> rsp_valid); // R8

    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> !rsp_valid); // R8

    AST_NO_BYTE_NO_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_be == 2'b00) |=> rsp_code == RSP_OKAY); // R6

    AST_SLVERR_LOGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == RSP_SLVERR) |-> ue_valid); // R9

    AST_CE_LANES_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ce_valid |-> ce_lanes != 2'b00); // R9

    AST_UE_LANES_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ue_valid |-> ue_lanes != 2'b00); // R9

    AST_CE_CNT_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ce_count >= $past(ce_count)); // R11

    AST_UE_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        ue_count == CNT_MAX |=> ue_count == CNT_MAX); // R11

endmodule

bind ecc_lane_datapath ecc_datapath_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_valid  (rd_valid),
    .rd_be     (rd_be),
    .rsp_valid (rsp_valid),
    .rsp_code  (rsp_code),
    .ce_valid  (ce_valid),
    .ce_lanes  (ce_lanes),
    .ce_count  (ce_count),
    .ue_valid  (ue_valid),
    .ue_lanes  (ue_lanes),
    .ue_count  (ue_count)
);

// File: tb/sim_ecc_lane_datapath.sv
module sim_ecc_lane_datapath;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] wr_data = '0;
    logic [31:0] wr_dq;
    logic        rd_valid = 1'b0;
    logic [31:0] rd_dq = '0;
    logic [1:0]  rd_be = '0;
    logic [9:0]  rd_col = '0;
    logic [14:0] rd_row = '0;
    logic [2:0]  rd_bank = '0;
    logic        clr_ce = 1'b0;
    logic        clr_ue = 1'b0;
    logic        rsp_valid;
    logic [15:0] rsp_data;
    logic [1:0]  rsp_code;
    logic        ce_valid, ue_valid;
    logic [9:0]  ce_col, ue_col;
    logic [14:0] ce_row, ue_row;
    logic [2:0]  ce_bank, ue_bank;
    logic [1:0]  ce_lanes, ue_lanes;
    logic [7:0]  ce_count, ue_count;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    ecc_lane_datapath u0 (.*);

    localparam logic [1:0] OKAY = 2'b00;
    localparam logic [1:0] SLV  = 2'b10;

    function automatic int r_pos(input int i);
        int p;
        p = (i < 1) ? 3 : (i < 4) ? i + 4 : i + 5;
        return p;
    endfunction

    function automatic logic [4:0] r_gen(input logic [7:0] d);
        logic [3:0] c;
        c = '0;
        for (int k = 0; k < 4; k++)
            for (int i = 0; i < 8; i++)
                if (((r_pos(i) >> k) & 1) == 1) c[k] = c[k] ^ d[i];
        return {(^d) ^ (^c), c};
    endfunction

    function automatic logic [31:0] r_pack(input logic [7:0] b0, input logic [7:0] b1);
        return {3'b000, r_gen(b1), 3'b000, r_gen(b0), b1, b0};
    endfunction

    // code bit j (0..7 data, 8..12 check field) of lane l -> bus lane
    function automatic logic [31:0] r_flip(input int l, input int j);
        int idx;
        idx = (j < 8) ? 8 * l + j : 16 + 8 * l + (j - 8);
        return 32'd1 << idx;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cmp(input string req, input logic [63:0] act, input logic [63:0] exp);
        check(act == exp, req, act, exp);
    endtask

    task automatic do_read(input logic [31:0] dq, input logic [1:0] be,
                           input logic [9:0] col, input logic [14:0] row,
                           input logic [2:0] bank, input bit cce, input bit cue);
        @(negedge clk);
        rd_valid = 1'b1; rd_dq = dq; rd_be = be;
        rd_col = col; rd_row = row; rd_bank = bank;
        clr_ce = cce; clr_ue = cue;
        @(negedge clk);
        rd_valid = 1'b0; clr_ce = 1'b0; clr_ue = 1'b0;
    endtask

    task automatic exp_rsp(input string req, input logic [1:0] code, input logic [15:0] data);
        cmp(req, {rsp_valid, rsp_code, rsp_data}, {1'b1, code, data});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] dq;
        logic [7:0]  vals [4];
        vals[0] = 8'h00; vals[1] = 8'hA5; vals[2] = 8'hFF; vals[3] = 8'h3C;

        repeat (3) @(negedge clk);
        // R12 reset state
        cmp("R12", {rsp_valid, ce_valid, ue_valid, ce_count, ue_count}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        cmp("R12", {rsp_valid, ce_valid, ue_valid, ce_count, ue_count}, '0);

        // R1 encoder sweep
        for (int v = 0; v < 256; v++) begin
            wr_data = {~v[7:0], v[7:0]};
            #1;
            cmp("R1", wr_dq, r_pack(v[7:0], ~v[7:0]));
        end

        // R8 response timing
        @(negedge clk);
        rd_valid = 1'b1; rd_dq = r_pack(8'h12, 8'h34); rd_be = 2'b11;
        cmp("R8", rsp_valid, 1'b0);
        @(negedge clk);
        rd_valid = 1'b0;
        exp_rsp("R8", OKAY, 16'h3412);
        @(negedge clk);
        cmp("R8", rsp_valid, 1'b0);

        // R2 clean reads
        for (int v = 0; v < 256; v++) begin
            do_read(r_pack(v[7:0], v[7:0] ^ 8'h5C), 2'b11, 10'd0, 15'd0, 3'd0, 0, 0);
            exp_rsp("R2", OKAY, {v[7:0] ^ 8'h5C, v[7:0]});
        end
        cmp("R9", {ce_valid, ue_valid, ce_count, ue_count}, '0);

        // R3 / R4 single flips in every code bit of both lanes
        for (int l = 0; l < 2; l++)
            for (int v = 0; v < 256; v++)
                for (int j = 0; j < 13; j++) begin
                    int n;
                    n = l * 256 * 13 + v * 13 + j;
                    dq = r_pack(v[7:0], ~v[7:0]) ^ r_flip(l, j);
                    if (n == 0) do_read(dq, 2'b11, 10'h123, 15'h0ABC, 3'd5, 0, 0);
                    else        do_read(dq, 2'b11, 10'h001, 15'h0002, 3'd1, 0, 0);
                    exp_rsp((j == 12) ? "R4" : "R3", OKAY, {~v[7:0], v[7:0]});
                    if (n == 0)
                        cmp("R9", {ce_valid, ce_lanes, ce_col, ce_row, ce_bank, ue_valid},
                            {1'b1, 2'b01, 10'h123, 15'h0ABC, 3'd5, 1'b0});
                    if (n == 2) cmp("R11", ce_count, 8'd3);
                end
        cmp("R9", {ce_valid, ce_lanes, ce_col, ce_row, ce_bank},
            {1'b1, 2'b01, 10'h123, 15'h0ABC, 3'd5});
        cmp("R11", {ce_count, ue_count}, {8'd255, 8'd0});

        // R5 double flips in lane 0
        for (int t = 0; t < 4; t++)
            for (int a = 0; a < 13; a++)
                for (int b = a + 1; b < 13; b++) begin
                    dq = r_pack(vals[t], 8'h77) ^ r_flip(0, a) ^ r_flip(0, b);
                    do_read(dq, 2'b11, 10'h2AA, 15'h1555, 3'd2, 0, 0);
                    exp_rsp("R5", SLV, dq[15:0]);
                    if (t == 0 && a == 0 && b == 1)
                        cmp("R9", {ue_valid, ue_lanes, ue_col, ue_count},
                            {1'b1, 2'b01, 10'h2AA, 8'd1});
                end
        cmp("R11", ue_count, 8'd255);

        // R10 clear alone empties both logs
        do_read(r_pack(8'h01, 8'h02), 2'b11, 10'd0, 15'd0, 3'd0, 1, 1);
        exp_rsp("R10", OKAY, 16'h0201);
        cmp("R10", {ce_valid, ue_valid}, 2'b00);

        // R7 spare lanes ignored
        do_read(r_pack(8'h9E, 8'h61) | 32'hE0E0_0000, 2'b11, 10'd0, 15'd0, 3'd0, 0, 0);
        exp_rsp("R7", OKAY, 16'h619E);
        cmp("R7", {ce_valid, ue_valid}, 2'b00);

        // R6 unselected byte with a double fault
        dq = r_pack(8'h4D, 8'hB2) ^ r_flip(1, 0) ^ r_flip(1, 5);
        do_read(dq, 2'b01, 10'd7, 15'd7, 3'd7, 0, 0);
        exp_rsp("R6", OKAY, dq[15:0]);
        cmp("R6", {ce_valid, ue_valid}, 2'b00);
        // R6 unselected byte with a single fault is not repaired
        dq = r_pack(8'h4D, 8'hB2) ^ r_flip(1, 3);
        do_read(dq, 2'b01, 10'd7, 15'd7, 3'd7, 0, 0);
        exp_rsp("R6", OKAY, dq[15:0]);
        cmp("R6", {ce_valid, ue_valid}, 2'b00);
        // R6 no byte selected, both faulty
        dq = r_pack(8'h11, 8'h22) ^ r_flip(0, 1) ^ r_flip(0, 9) ^ r_flip(1, 2) ^ r_flip(1, 4);
        do_read(dq, 2'b00, 10'd7, 15'd7, 3'd7, 0, 0);
        exp_rsp("R6", OKAY, dq[15:0]);
        cmp("R6", {ce_valid, ue_valid}, 2'b00);

        // R9 mixed read: byte 0 single, byte 1 double
        dq = r_pack(8'hC3, 8'h5A) ^ r_flip(0, 6) ^ r_flip(1, 1) ^ r_flip(1, 10);
        do_read(dq, 2'b11, 10'h3F0, 15'h7001, 3'd6, 0, 0);
        exp_rsp("R9", SLV, {dq[15:8], 8'hC3});
        cmp("R9", {ue_valid, ue_lanes, ue_col, ue_row, ue_bank, ce_valid},
            {1'b1, 2'b11, 10'h3F0, 15'h7001, 3'd6, 1'b0});

        // R10 clear coinciding with a new error reloads
        do_read(r_pack(8'h10, 8'h20) ^ r_flip(1, 2), 2'b11, 10'h0AA, 15'd3, 3'd3, 0, 0);
        cmp("R9", {ce_valid, ce_lanes, ce_col}, {1'b1, 2'b10, 10'h0AA});
        do_read(r_pack(8'h10, 8'h20) ^ r_flip(0, 4), 2'b11, 10'h155, 15'd4, 3'd4, 1, 0);
        cmp("R10", {ce_valid, ce_lanes, ce_col, ce_row, ce_bank},
            {1'b1, 2'b01, 10'h155, 15'd4, 3'd4});
        do_read(r_pack(8'h10, 8'h20), 2'b11, 10'd0, 15'd0, 3'd0, 1, 0);
        cmp("R10", {ce_valid, ue_valid}, 2'b01);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule